// File: doc/BRIEF.md
# Flash Write-Status Polling Output Generator

This block models the status side of a byte-wide parallel flash memory while an internal program or erase operation runs. When a program or erase command is accepted, the block takes over the read data path: reads aimed at the operation's target return a status byte rather than stored contents. The host polls that byte to learn whether the operation is still running, has finished, has been suspended, or has run past its time limit. Command decoding sits upstream, and so does the storage array. The only stored contents the block holds are the one datum it was last asked to program and a record of which sectors its last erase cleared.

Status byte layout: bit 7 is the polling bit, bit 6 toggles on each live status read, bit 5 flags an exceeded time limit, and bits 4..0 read 0. A microsecond tick input paces every interval. Targets in protected sectors give a fixed-length false busy period and then go back to plain array reads. An erase can be suspended, a byte outside the erasing sectors can be programmed during the suspension, and the erase can then resume. A fault-injection input stalls the running operation and raises bit 5 so the host's failure path can be tested.

Top module: `fsp_status_gen`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` is 0x00. With no operation ever started, a read returns `array_rdata` unchanged.
- R2: While a program runs, `busy` is 1. A read at the program address returns bit 7 = inverse of bit 7 of the datum being programmed, with bit 5 = 0 and bits 4..0 = 0. Bit 6 differs between two consecutive such reads.
- R3: A program in an unprotected sector finishes on the PGM_US-th tick after the command. `busy` is still 1 after PGM_US-1 ticks and 0 after PGM_US ticks. Reads at the program address then return the full programmed datum.
- R4: While any operation runs, reads at addresses that are not its status target return `array_rdata`.
- R5: While an erase runs, reads in any sector selected for erase return bit 7 = 0. The erase finishes on the ERS_US-th tick. After that, reads in the selected unprotected sectors return 0xFF.
- R6: When some of the selected sectors are protected, the erase still takes ERS_US ticks. The protected ones are skipped: after completion, reads there return `array_rdata`.
- R7: A program whose address lies in a sector flagged in `prot_mask` shows program status for PROT_PGM_US ticks. It then ends without storing anything, and reads at that address return `array_rdata`.
- R8: An erase whose selected sectors are all protected shows erase status for PROT_ERS_US ticks. It then ends, and no sector reads 0xFF.
- R9: A suspend pulse during an unprotected erase makes `busy` 0 on the next cycle. Reads in a selected sector then return bit 7 = 1 with bit 6 unchanged between reads. Ticks do not advance the erase while it is suspended. After a resume pulse, the erase needs exactly its remaining ticks.
- R10: While an erase is suspended, a program to a sector that is not selected for erase runs with the same inverse/true bit-7 rule and then goes back to the suspended state. A program to a selected sector is ignored.
- R11: While `fault_inj` is 1 during a running operation, a status read returns bit 5 = 1 and bit 7 at its in-progress value, and ticks do not advance the operation.
- R12: Program and erase commands that arrive while `busy` is 1 are ignored: the running operation keeps its address, datum and finishing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cmd_pgm | input | 1 | Program command pulse |
| cmd_erase | input | 1 | Erase command pulse |
| cmd_suspend | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | 8 | Datum to program |
| ers_sel | input | NSECT | Sectors selected for erase (all ones for whole-chip erase) |
| prot_mask | input | NSECT | Per-sector protection flags, sampled at command time |
| fault_inj | input | 1 | Forces the time-limit-exceeded status and stalls the operation |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 8 | Array contents at `rd_addr`, valid with `rd_en` |
| rd_data | output | 8 | Read result, registered, updated the cycle after `rd_en` |
| busy | output | 1 | An operation is running (0 while idle or suspended) |

## Verification
The bench builds the block with ADDR_W = 8 and NSECT = 4, which gives 64-byte sectors whose edges are easy to address. It uses PGM_US = 4 and ERS_US = 12, so the tick just before and the tick at which each operation ends can both be reached in a few dozen cycles. PROT_PGM_US and PROT_ERS_US stay at 2 and 100, which lets the full protected-erase window run to its end. The suspend scenario stops the erase after 5 of its 12 ticks, so the remaining-tick count after resume differs from both zero and the full duration.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PGM  = 3'd1,
    ST_ERS  = 3'd2,
    ST_SUSP = 3'd3,
    ST_SPGM = 3'd4
  } op_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // status byte: poll, toggle, time-limit flag, five zero bits
  function automatic logic [7:0] status_byte(input logic poll, input logic tog,
                                             input logic xfail);
    return {poll, tog, xfail, 5'b0_0000};
  endfunction

  function automatic logic is_pgm_state(input op_state_e s);
    return (s == ST_PGM) || (s == ST_SPGM);
  endfunction

  function automatic logic is_running(input op_state_e s);
    return (s == ST_PGM) || (s == ST_SPGM) || (s == ST_ERS);
  endfunction

endpackage

// File: rtl/fsp_interval_timer.sv
module fsp_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  assign done = run && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run) begin
      cnt <= done ? '0 : cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/fsp_sector_lookup.sv
module fsp_sector_lookup #(
  parameter int ADDR_W = 19,
  parameter int NSECT  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSECT-1:0]  mask_a,
  input  logic [NSECT-1:0]  mask_b,
  output logic              hit_a,
  output logic              hit_b
);

  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1;

  logic [SECT_W-1:0] sect;

  assign sect  = addr[ADDR_W-1 -: SECT_W];
  assign hit_a = mask_a[sect];
  assign hit_b = mask_b[sect];

endmodule

// File: rtl/fsp_read_mux.sv
module fsp_read_mux
  import fsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_en,
  input  op_state_e state,
  input  logic      addr_hit,
  input  logic      in_sel,
  input  logic      sect_erased,
  input  logic      pgm_stored,
  input  logic [7:0] pgm_datum,
  input  logic      tog,
  input  logic      fault_inj,
  input  logic [7:0] array_rdata,
  output logic      live_hit,
  output logic      ers_hit,
  output logic [7:0] rd_data
);

  logic       pgm_hit;
  logic       susp_hit;
  logic       stat_hit;
  logic       poll;
  logic [7:0] nxt;

  assign pgm_hit  = is_pgm_state(state) && addr_hit;
  assign ers_hit  = (state == ST_ERS) && in_sel;
  assign susp_hit = ((state == ST_SUSP) || (state == ST_SPGM)) && in_sel && !pgm_hit;
  assign live_hit = pgm_hit || ers_hit;
  assign stat_hit = live_hit || susp_hit;

  always_comb begin
    if (pgm_hit)      poll = ~pgm_datum[7];
    else if (ers_hit) poll = 1'b0;
    else              poll = 1'b1;
  end

  always_comb begin
    if (stat_hit)                    nxt = status_byte(poll, tog, live_hit && fault_inj);
    else if (pgm_stored && addr_hit) nxt = pgm_datum;
    else if (sect_erased)            nxt = 8'hFF;
    else                             nxt = array_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= nxt;
  end

endmodule

// File: rtl/fsp_status_gen.sv
module fsp_status_gen
  import fsp_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int NSECT       = 8,
  parameter int PGM_US      = 7,
  parameter int ERS_US      = 500,
  parameter int PROT_PGM_US = 2,
  parameter int PROT_ERS_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              cmd_pgm,
  input  logic              cmd_erase,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NSECT-1:0]  ers_sel,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              fault_inj,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int MAX_US = max_of(max_of(PGM_US, ERS_US), max_of(PROT_PGM_US, PROT_ERS_US));
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam logic [CNT_W-1:0] LD_PGM  = CNT_W'(PGM_US);
  localparam logic [CNT_W-1:0] LD_PPGM = CNT_W'(PROT_PGM_US);
  localparam logic [CNT_W-1:0] LD_ERS  = CNT_W'(ERS_US);
  localparam logic [CNT_W-1:0] LD_PERS = CNT_W'(PROT_ERS_US);

  op_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  pa_q;
  logic [7:0]         pd_q;
  logic               pprot_q;
  logic               pgm_done_q;
  logic [NSECT-1:0]   sel_q;
  logic [NSECT-1:0]   ers_eff_q;
  logic               eprot_q;
  logic [NSECT-1:0]   ers_done_q;
  logic               tog_q;

  logic               c_prot, c_in_sel;
  logic               r_in_sel, r_erased;
  logic [NSECT-1:0]   ers_eff_d;

  // named internal events
  logic               accept_pgm, accept_ers, susp_go, resume_go;
  logic               pgm_run, ers_run, pgm_done_ev, ers_done_ev, op_done;
  logic [CNT_W-1:0]   pgm_cnt, ers_cnt;
  logic               live_hit, ers_hit, live_rd, ers_rd;

  fsp_sector_lookup #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_lk_cmd (
    .addr(cmd_addr), .mask_a(prot_mask), .mask_b(sel_q),
    .hit_a(c_prot), .hit_b(c_in_sel)
  );

  fsp_sector_lookup #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_lk_rd (
    .addr(rd_addr), .mask_a(sel_q), .mask_b(ers_done_q),
    .hit_a(r_in_sel), .hit_b(r_erased)
  );

  assign ers_eff_d  = ers_sel & ~prot_mask;
  assign accept_pgm = cmd_pgm && ((state_q == ST_IDLE) || ((state_q == ST_SUSP) && !c_in_sel));
  assign accept_ers = cmd_erase && !cmd_pgm && (state_q == ST_IDLE) && (|ers_sel);
  assign pgm_run    = us_tick && is_pgm_state(state_q) && !fault_inj;
  assign ers_run    = us_tick && (state_q == ST_ERS) && !fault_inj;
  assign susp_go    = cmd_suspend && (state_q == ST_ERS) && !eprot_q && !ers_done_ev;
  assign resume_go  = cmd_resume && !cmd_pgm && (state_q == ST_SUSP);
  assign op_done    = pgm_done_ev || ers_done_ev;

  fsp_interval_timer #(.CNT_W(CNT_W)) u_tmr_pgm (
    .clk(clk), .rst_n(rst_n), .load(accept_pgm),
    .load_val(c_prot ? LD_PPGM : LD_PGM),
    .run(pgm_run), .cnt(pgm_cnt), .done(pgm_done_ev)
  );

  fsp_interval_timer #(.CNT_W(CNT_W)) u_tmr_ers (
    .clk(clk), .rst_n(rst_n), .load(accept_ers),
    .load_val((|ers_eff_d) ? LD_ERS : LD_PERS),
    .run(ers_run), .cnt(ers_cnt), .done(ers_done_ev)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_pgm)      state_d = ST_PGM;
        else if (accept_ers) state_d = ST_ERS;
      end
      ST_PGM:  if (pgm_done_ev) state_d = ST_IDLE;
      ST_ERS: begin
        if (ers_done_ev)  state_d = ST_IDLE;
        else if (susp_go) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (accept_pgm)     state_d = ST_SPGM;
        else if (resume_go) state_d = ST_ERS;
      end
      ST_SPGM: if (pgm_done_ev) state_d = ST_SUSP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pa_q       <= '0;
      pd_q       <= 8'h00;
      pprot_q    <= 1'b0;
      pgm_done_q <= 1'b0;
      sel_q      <= '0;
      ers_eff_q  <= '0;
      eprot_q    <= 1'b0;
      ers_done_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_pgm) begin
        pa_q       <= cmd_addr;
        pd_q       <= cmd_data;
        pprot_q    <= c_prot;
        pgm_done_q <= 1'b0;
      end else if (pgm_done_ev) begin
        pgm_done_q <= !pprot_q;
      end
      if (accept_ers) begin
        sel_q      <= ers_sel;
        ers_eff_q  <= ers_eff_d;
        eprot_q    <= ~(|ers_eff_d);
        ers_done_q <= '0;
        pgm_done_q <= 1'b0;
      end else if (ers_done_ev) begin
        ers_done_q <= ers_eff_q;
      end
    end
  end

  fsp_read_mux u_mux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .state(state_q),
    .addr_hit(rd_addr == pa_q), .in_sel(r_in_sel), .sect_erased(r_erased),
    .pgm_stored(pgm_done_q), .pgm_datum(pd_q), .tog(tog_q),
    .fault_inj(fault_inj), .array_rdata(array_rdata),
    .live_hit(live_hit), .ers_hit(ers_hit), .rd_data(rd_data)
  );

  assign live_rd = rd_en && live_hit;
  assign ers_rd  = rd_en && ers_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (live_rd) tog_q <= ~tog_q;
  end

  assign busy = is_running(state_q);

endmodule

// File: rtl/fsp_status_chk.sv
module fsp_status_chk #(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              op_done,
  input logic              susp_go,
  input logic              fault_inj,
  input logic              cmd_pgm,
  input logic              live_rd,
  input logic              ers_rd,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] pa_q,
  input logic [CNT_W-1:0]  pgm_cnt,
  input logic [CNT_W-1:0]  ers_cnt
);

  p_done_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy);

  p_erase_poll_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ers_rd |=> !rd_data[7]);

  p_suspend_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |=> !busy);

  p_fault_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (live_rd && fault_inj) |=> rd_data[5]);

  p_fault_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fault_inj) |=> ($stable(pgm_cnt) && $stable(ers_cnt)));

  p_busy_cmd_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_pgm) |=> $stable(pa_q));

endmodule

bind fsp_status_gen fsp_status_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_done(op_done), .susp_go(susp_go),
  .fault_inj(fault_inj), .cmd_pgm(cmd_pgm), .live_rd(live_rd), .ers_rd(ers_rd),
  .rd_data(rd_data), .pa_q(pa_q), .pgm_cnt(pgm_cnt), .ers_cnt(ers_cnt)
);

// File: tb/sim_fsp_status_gen.sv
module sim_fsp_status_gen;

  localparam int AW = 8;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          us_tick = 1'b0;
  logic          cmd_pgm = 1'b0, cmd_erase = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'h00;
  logic [NS-1:0] ers_sel = '0;
  logic [NS-1:0] prot_mask = '0;
  logic          fault_inj = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    array_rdata = 8'h00;
  logic [7:0]    rd_data;
  logic          busy;

  int vectors = 0;
  int miscmp  = 0;

  always #2 clk = ~clk;

  fsp_status_gen #(
    .ADDR_W(AW), .NSECT(NS), .PGM_US(4), .ERS_US(12),
    .PROT_PGM_US(2), .PROT_ERS_US(100)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .cmd_pgm(cmd_pgm), .cmd_erase(cmd_erase), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .ers_sel(ers_sel), .prot_mask(prot_mask), .fault_inj(fault_inj),
    .rd_en(rd_en), .rd_addr(rd_addr), .array_rdata(array_rdata),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic chk_busy(input string req, input logic exp);
    chk(req, {7'b0, busy}, {7'b0, exp});
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] arr, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; array_rdata = arr;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  task automatic pgm(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); cmd_pgm = 1'b1; cmd_addr = a; cmd_data = d;
    @(negedge clk); cmd_pgm = 1'b0;
  endtask

  task automatic ers(input logic [NS-1:0] s);
    @(negedge clk); cmd_erase = 1'b1; ers_sel = s;
    @(negedge clk); cmd_erase = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk_busy("R1 busy at reset", 1'b0);
    chk("R1 rd_data at reset", rd_data, 8'h00);
    rd(8'h10, 8'h5A, v);
    chk("R1 idle read", v, 8'h5A);
  endtask

  task automatic t_program;
    logic [7:0] v1, v2, v;
    prot_mask = '0;
    pgm(8'h23, 8'hC5);
    chk_busy("R2 busy during program", 1'b1);
    rd(8'h23, 8'h00, v1);
    chk("R2 status inverse bit7", v1 & 8'hBF, 8'h00);
    rd(8'h23, 8'h00, v2);
    chk("R2 toggle bit6", (v1 ^ v2) & 8'h40, 8'h40);
    rd(8'h24, 8'h11, v);
    chk("R4 other address array", v, 8'h11);
    pgm(8'h30, 8'h00);           // R12 ignored while busy
    ers(4'b1111);                // R12 ignored while busy
    rd(8'h23, 8'h00, v);
    chk("R12 datum kept", v & 8'hBF, 8'h00);
    tick(3);
    chk_busy("R3 busy before last tick", 1'b1);
    tick(1);
    chk_busy("R3 done on last tick", 1'b0);
    rd(8'h23, 8'h00, v);
    chk("R3 true datum", v, 8'hC5);
    rd(8'h30, 8'h99, v);
    chk("R12 ignored program not stored", v, 8'h99);
    pgm(8'h2A, 8'h35);
    rd(8'h2A, 8'h00, v);
    chk("R2 status bit7 for zero msb", v & 8'hBF, 8'h80);
    tick(4);
    chk_busy("R3 second program done", 1'b0);
    rd(8'h2A, 8'h00, v);
    chk("R3 second datum", v, 8'h35);
  endtask

  task automatic t_erase;
    logic [7:0] v;
    prot_mask = 4'b0100;
    ers(4'b0110);
    chk_busy("R5 busy during erase", 1'b1);
    rd(8'h45, 8'h00, v);
    chk("R5 erase poll zero", v & 8'hBF, 8'h00);
    rd(8'h85, 8'h00, v);
    chk("R6 protected selected polls", v & 8'hBF, 8'h00);
    rd(8'h05, 8'h21, v);
    chk("R4 unselected array", v, 8'h21);
    tick(11);
    chk_busy("R6 erase not done early", 1'b1);
    tick(1);
    chk_busy("R5 erase done", 1'b0);
    rd(8'h45, 8'h00, v);
    chk("R5 erased reads FF", v, 8'hFF);
    rd(8'h85, 8'h3C, v);
    chk("R6 protected sector skipped", v, 8'h3C);
    rd(8'h05, 8'h22, v);
    chk("R5 unselected after erase", v, 8'h22);
  endtask

  task automatic t_prot_pgm;
    logic [7:0] v;
    prot_mask = 4'b1000;
    pgm(8'hC1, 8'h80);
    rd(8'hC1, 8'h00, v);
    chk("R7 protected program status", v & 8'hBF, 8'h00);
    tick(1);
    chk_busy("R7 still busy", 1'b1);
    tick(1);
    chk_busy("R7 timeout ends", 1'b0);
    rd(8'hC1, 8'h77, v);
    chk("R7 array after timeout", v, 8'h77);
  endtask

  task automatic t_prot_ers;
    logic [7:0] v;
    prot_mask = 4'b0001;
    ers(4'b0001);
    rd(8'h10, 8'h00, v);
    chk("R8 all protected status", v & 8'hBF, 8'h00);
    tick(99);
    chk_busy("R8 still busy at 99", 1'b1);
    tick(1);
    chk_busy("R8 ends at 100", 1'b0);
    rd(8'h10, 8'h6B, v);
    chk("R8 array after timeout", v, 8'h6B);
    rd(8'h45, 8'h6C, v);
    chk("R8 no sector erased", v, 8'h6C);
  endtask

  task automatic t_suspend;
    logic [7:0] v1, v2, v;
    prot_mask = '0;
    ers(4'b0010);
    tick(5);
    @(negedge clk); cmd_suspend = 1'b1;
    @(negedge clk); cmd_suspend = 1'b0;
    chk_busy("R9 suspend clears busy", 1'b0);
    rd(8'h50, 8'h00, v1);
    chk("R9 suspended poll one", v1 & 8'hBF, 8'h80);
    rd(8'h50, 8'h00, v2);
    chk("R9 bit6 steady", (v1 ^ v2) & 8'h40, 8'h00);
    tick(20);
    chk_busy("R9 ticks frozen", 1'b0);
    pgm(8'h60, 8'hAA);
    chk_busy("R10 selected-sector program ignored", 1'b0);
    pgm(8'h02, 8'h7E);
    chk_busy("R10 suspend program busy", 1'b1);
    rd(8'h02, 8'h00, v);
    chk("R10 suspend program inverse", v & 8'hBF, 8'h80);
    rd(8'h50, 8'h00, v);
    chk("R10 erase still suspended", v & 8'hBF, 8'h80);
    tick(4);
    chk_busy("R10 back to suspend", 1'b0);
    rd(8'h02, 8'h00, v);
    chk("R10 true datum", v, 8'h7E);
    @(negedge clk); cmd_resume = 1'b1;
    @(negedge clk); cmd_resume = 1'b0;
    chk_busy("R9 resume busy", 1'b1);
    rd(8'h50, 8'h00, v);
    chk("R9 resumed poll zero", v & 8'hBF, 8'h00);
    tick(6);
    chk_busy("R9 remaining not done", 1'b1);
    tick(1);
    chk_busy("R9 remaining done", 1'b0);
    rd(8'h50, 8'h00, v);
    chk("R9 erased after resume", v, 8'hFF);
  endtask

  task automatic t_fault;
    logic [7:0] v;
    prot_mask = '0;
    pgm(8'h10, 8'h01);
    tick(2);
    @(negedge clk); fault_inj = 1'b1;
    rd(8'h10, 8'h00, v);
    chk("R11 fault flag and poll", v & 8'hBF, 8'hA0);
    tick(10);
    chk_busy("R11 stalled", 1'b1);
    @(negedge clk); fault_inj = 1'b0;
    rd(8'h10, 8'h00, v);
    chk("R11 flag clears", v & 8'hBF, 8'h80);
    tick(1);
    chk_busy("R11 resumes count", 1'b1);
    tick(1);
    chk_busy("R11 completes", 1'b0);
    rd(8'h10, 8'h00, v);
    chk("R11 datum", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_erase;
    t_prot_pgm;
    t_prot_ers;
    t_suspend;
    t_fault;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    #800000;
    miscmp++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule